// File: doc/BRIEF.md
# Bidirectional universal shift register

A parameterised register of `WIDTH` bits with four synchronous modes, chosen on each rising clock edge by a two-bit code. The register can keep its contents, move them one place toward the high index, move them one place toward the low index, or take a new word from the parallel input. Each shift direction has its own serial input, and the two inputs feed opposite ends of the word. Every bit of the register is driven out in parallel.

An active-low clear works without the clock and outranks every other input. Its typical uses are serial-to-parallel and parallel-to-serial conversion, rotation (the top output fed back into the up-shift serial input), and staging data that can be held for any number of cycles. The width must be at least 2, and the default is 4. Bit `i` of `par_in` maps to bit `i` of `q_out`.

Top module: `usr_shift_reg`

## Requirements
- R1: While `clr_n` is low, every bit of `q_out` is 0 at once, with no clock edge needed and whatever the mode and data inputs are.
- R2: With `mode` = 2'b00, a rising edge leaves `q_out` unchanged.
- R3: With `mode` = 2'b01, a rising edge moves the word toward the high index. Bit 0 takes `ser_up_in`, and each bit i>0 takes the old bit i-1.
- R4: With `mode` = 2'b10, a rising edge moves the word toward the low index. Bit WIDTH-1 takes `ser_down_in`, and each bit i<WIDTH-1 takes the old bit i+1.
- R5: With `mode` = 2'b11, a rising edge copies `par_in` into the register. Both serial inputs have no effect on the result.
- R6: Mode, serial and parallel inputs take effect only at a rising edge, using the values they hold just before that edge. Changing them between edges leaves `q_out` unchanged.
- R7: After `clr_n` is released with the clock steady, `q_out` stays 0 until the next rising edge. That edge then applies the current mode.
- R8: If `q_out[WIDTH-1]` is fed back into `ser_up_in` in mode 2'b01, the word rotates. After WIDTH edges it equals its starting value, and after WIDTH+1 edges it equals the starting value rotated by one place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operating code: 00 keep, 01 shift up, 10 shift down, 11 load |
| ser_up_in | input | 1 | Serial bit entering bit 0 during an up shift |
| ser_down_in | input | 1 | Serial bit entering bit WIDTH-1 during a down shift |
| par_in | input | WIDTH | Parallel load word |
| q_out | output | WIDTH | Register contents |

## Verification
Every synchronous result (R2 to R5, R8) shows on `q_out` one register stage after the rising edge that samples the inputs. The bench drives the inputs on the falling edge, computes the next value of its model at that point, and compares one time unit after the following rising edge. Clear (R1) has no delay, so it is checked one time unit after `clr_n` falls, in the middle of a clock phase. The cases for R6 and R7 are checked between edges, before any rising edge could move the register.

// File: rtl/usr_pkg.sv
// Package: shared types for the universal shift register.
// Assumes: nothing beyond IEEE 1800-2017.
package usr_pkg;

    // Raw two-bit operating codes presented on the mode port.
    typedef enum logic [1:0] {
        MODE_KEEP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_DOWN = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

    // Source each bit cell selects for its next value.
    typedef enum logic [1:0] {
        SRC_SELF = 2'd0,
        SRC_LOW  = 2'd1,
        SRC_HIGH = 2'd2,
        SRC_PAR  = 2'd3
    } usr_src_e;

endpackage

// File: rtl/usr_mode_decode.sv
// Module: usr_mode_decode
// Turns the raw mode code into the source that every bit cell selects.
// Assumes: the code is sampled with the cells at the same clock edge.
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_raw,
    output usr_src_e   src_sel
);

    // Purpose: map each operating code onto a bit-cell source.
    always_comb begin
        case (mode_raw)
            MODE_UP:   src_sel = SRC_LOW;
            MODE_DOWN: src_sel = SRC_HIGH;
            MODE_LOAD: src_sel = SRC_PAR;
            default:   src_sel = SRC_SELF;
        endcase
    end

endmodule

// File: rtl/usr_bit_cell.sv
// Module: usr_bit_cell
// One storage bit with a four-way next-value mux and an asynchronous active-low clear.
// Assumes: the neighbour inputs are wired by the parent (serial inputs at the ends).
module usr_bit_cell
    import usr_pkg::*;
(
    input  logic     clk,
    input  logic     clr_n,
    input  usr_src_e src_sel,
    input  logic     from_low,
    input  logic     from_high,
    input  logic     par_bit,
    output logic     q
);

    logic nxt;

    // Purpose: choose the value this bit takes at the next rising edge.
    always_comb begin
        case (src_sel)
            SRC_LOW:  nxt = from_low;
            SRC_HIGH: nxt = from_high;
            SRC_PAR:  nxt = par_bit;
            default:  nxt = q;
        endcase
    end

    // Purpose: store the bit; clear wins at any time.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= 1'b0;
        else        q <= nxt;
    end

endmodule

// File: rtl/usr_shift_reg.sv
// Module: usr_shift_reg (top)
// WIDTH-bit universal shift register: keep, shift up, shift down, parallel load.
// Assumes: WIDTH >= 2; clr_n may change at any time, other inputs are synchronous.
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_up_in,
    input  logic             ser_down_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out
);

    localparam int TOP = WIDTH - 1;

    generate
        if (WIDTH < 2) begin : g_bad_width
            $error("usr_shift_reg: WIDTH must be at least 2");
        end
    endgenerate

    usr_src_e         src_sel;
    logic [WIDTH-1:0] lo_feed;
    logic [WIDTH-1:0] hi_feed;

    usr_mode_decode u_dec (
        .mode_raw (mode),
        .src_sel  (src_sel)
    );

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Neighbour toward index 0: the up-shift serial input at the bottom end.
            if (i == 0) begin : g_lo_end
                assign lo_feed[i] = ser_up_in;
            end else begin : g_lo_mid
                assign lo_feed[i] = q_out[i-1];
            end
            // Neighbour toward the top index: the down-shift serial input at the top end.
            if (i == TOP) begin : g_hi_end
                assign hi_feed[i] = ser_down_in;
            end else begin : g_hi_mid
                assign hi_feed[i] = q_out[i+1];
            end

            usr_bit_cell u_cell (
                .clk       (clk),
                .clr_n     (clr_n),
                .src_sel   (src_sel),
                .from_low  (lo_feed[i]),
                .from_high (hi_feed[i]),
                .par_bit   (par_in[i]),
                .q         (q_out[i])
            );
        end
    endgenerate

    // R1: clear seen at an edge means an all-zero word.
    a_r1_clear_zero: assert property (@(posedge clk) !clr_n |-> q_out == '0);

    // R2: keep mode leaves the word unchanged.
    a_r2_keep: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b00 |=> $stable(q_out));

    // R3: up shift enters ser_up_in at bit 0.
    a_r3_up: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b01 |=> q_out == {$past(q_out[TOP-1:0]), $past(ser_up_in)});

    // R4: down shift enters ser_down_in at the top bit.
    a_r4_down: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b10 |=> q_out == {$past(ser_down_in), $past(q_out[TOP:1])});

    // R5: load copies the parallel word.
    a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b11 |=> q_out == $past(par_in));

endmodule

// File: tb/tb_usr_shift_reg.sv
// Bench for usr_shift_reg at WIDTH=4: near-exhaustive sweep against an arithmetic model.
module tb_usr_shift_reg;

    localparam int W          = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic         ser_up_in = 1'b0;
    logic         ser_down_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] q_out;
    logic [W-1:0] exp_q = '0;

    int checks = 0;
    int errors = 0;

    usr_shift_reg #(.WIDTH(W)) dut (
        .clk         (clk),
        .clr_n       (clr_n),
        .mode        (mode),
        .ser_up_in   (ser_up_in),
        .ser_down_in (ser_down_in),
        .par_in      (par_in),
        .q_out       (q_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Drive on the falling edge, model the next value, compare just after the rising edge.
    task automatic step(input logic [1:0] m, input logic su, input logic sd,
                        input logic [W-1:0] p, input string req);
        @(negedge clk);
        mode = m; ser_up_in = su; ser_down_in = sd; par_in = p;
        case (m)
            2'b00: exp_q = exp_q;
            2'b01: exp_q = ((exp_q << 1) | W'(su)) & MASK;
            2'b10: exp_q = (exp_q >> 1) | (W'(sd) << (W-1));
            default: exp_q = p;
        endcase
        @(posedge clk);
        #1;
        check(req, q_out, exp_q);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: q_out=%b expected=run complete", q_out);
        finish_run();
    end

    initial begin
        logic [W-1:0] start;
        #1 clr_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", q_out, '0);
        @(negedge clk);
        clr_n = 1'b1;
        #1;
        check("R7 stays zero after release", q_out, '0);

        // Sweep: preload every word, then apply every mode with every serial pair.
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 16; p++) begin
                for (int s = 0; s < 4; s++) begin
                    step(2'b11, s[0], s[1], W'(p), "R5 preload");
                    case (m)
                        0: step(2'(m), s[0], s[1], ~W'(p), "R2 keep");
                        1: step(2'(m), s[0], s[1], ~W'(p), "R3 shift up");
                        2: step(2'(m), s[0], s[1], ~W'(p), "R4 shift down");
                        default: step(2'(m), s[0], s[1], W'(p + 5), "R5 load ignores serial");
                    endcase
                end
            end
        end

        // R6: inputs changing between edges do not move the register.
        step(2'b11, 1'b0, 1'b0, 4'b0110, "R5 load");
        @(negedge clk);
        mode = 2'b11; par_in = 4'b1001; #1;
        check("R6 no change without edge", q_out, 4'b0110);
        mode = 2'b01; ser_up_in = 1'b1; #1;
        check("R6 no change without edge", q_out, 4'b0110);

        // R1: clear in the middle of the high phase.
        step(2'b11, 1'b1, 1'b1, 4'b1111, "R5 load");
        #2 clr_n = 1'b0;
        #1;
        exp_q = '0;
        check("R1 async clear", q_out, '0);
        @(posedge clk); #1;
        check("R1 clear holds over edge", q_out, '0);
        @(negedge clk);
        mode = 2'b11; par_in = 4'b1010;
        clr_n = 1'b1; #1;
        check("R7 zero until edge", q_out, '0);
        @(posedge clk); #1;
        exp_q = 4'b1010;
        check("R7 first edge applies mode", q_out, exp_q);

        // R8: rotation through ser_up_in for W+1 edges.
        step(2'b11, 1'b0, 1'b0, 4'b1011, "R5 load");
        start = exp_q;
        for (int k = 1; k <= W + 1; k++) begin
            step(2'b01, exp_q[W-1], 1'b0, '0, "R3 rotate");
            if (k == W) check("R8 full turn", q_out, start);
        end
        check("R8 turn plus one", q_out, {start[W-2:0], start[W-1]});

        finish_run();
    end

endmodule